// File: doc/BRIEF.md
# SPI Register and Flag Unit

This block is the register file between a processor bus and a serial shift engine. It holds the control byte, the status byte with its clock-rate field, a one-byte transmit holding buffer and a one-byte receive holding buffer. It sets and clears the receive-full, transmit-empty, overrun and mode-fault flags. The flags clear only through defined bus access sequences. It also raises receive and transmit requests, which go to either the processor interrupt lines or the DMA request lines.

The bus side is a plain port. The address selects control (0), status (1) or data (2), and address 3 reads as zero. Read data is combinational from the address. Side effects of a read take place on the clock edge while `bus_rd` is high.

Two streams face the shift engine:
- **Transmit stream:** `tx_valid`/`tx_ready`/`tx_data`. `tx_valid` is high while the buffer holds a byte and the unit is enabled. The engine may hold `tx_ready` low for as long as it wants, and the byte then stays put. A byte transfers on any edge where both signals are high.
- **Receive stream:** `rx_valid`/`rx_data`. This stream has no ready signal. The engine cannot be held back, so a byte that arrives while the buffer is still unread is dropped and flagged.

Top module: `spi_flag_regs`

## Requirements
- R1: After reset, control reads 0x08, status reads 0x08, all four request outputs are low and `tx_valid` is low.
- R2: A write to address 0 stores all 8 bits, and they read back unchanged. The bit map is: 7 receive request enable, 6 DMA route select, 5 master, 4 clock polarity, 3 clock phase, 2 open-drain select, 1 enable, 0 transmit request enable. Bits 5..1 drive the matching `cfg_*` outputs.
- R3: Status reads as {rx_full, 0, overrun, mode_fault, tx_empty, 0, rate[1:0]}. A write to address 1 changes only the rate bits (shown on `cfg_rate`). Writes to the flag bits and the zero bits have no effect.
- R4: A data write loads the transmit buffer and clears tx_empty. While enabled, `tx_valid` is high with the byte on `tx_data`. A transfer on the stream sets tx_empty on that edge.
- R5: A received byte with rx_full clear is stored and sets rx_full. A data read returns the receive buffer.
- R6: rx_full clears only on a data read that follows a status read which saw it set. A data read alone leaves it set.
- R7: A byte that arrives while rx_full is set is lost: the buffer keeps its old byte and overrun sets. Overrun clears by the same status-then-data read sequence.
- R8: A byte that arrives on the same edge as the clearing data read is stored. rx_full stays set and overrun does not set.
- R9: Mode fault sets only in master mode with enable high, two clocks after `ss_n` goes low. It forces enable low and keeps it low. A status write clears the fault.
- R10: Receive request = rx_full AND bit 7, and transmit request = tx_empty AND bit 0. With bit 6 set, both go to the DMA lines; otherwise both go to the interrupt lines.
- R11: A data write on the same edge as a stream transfer hands the old byte to the engine and keeps the new one. tx_empty stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Engine delivers a byte |
| rx_data | input | 8 | Received byte |
| ss_n | input | 1 | Select pin, asynchronous |
| cfg_master | output | 1 | Master mode |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cpha | output | 1 | Clock phase |
| cfg_wired_or | output | 1 | Open-drain outputs |
| cfg_enable | output | 1 | Unit enabled |
| cfg_rate | output | 2 | Clock-rate select |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| dma_rx | output | 1 | Receive DMA request |
| dma_tx | output | 1 | Transmit DMA request |

## Verification
Two pairs of functions can fall in the same cycle.
- **Receive side:** the bench raises `rx_valid` in the same cycle as the clearing data read. It checks that the read still returns the old byte, that rx_full stays set without overrun, and that the next read returns the new byte.
- **Transmit side:** the bench holds `tx_ready` high during a data write to a full buffer. It checks that `tx_data` showed the old byte before the edge, and that the new byte and a clear tx_empty remain after it.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic rx_ie;
    logic dma_sel;
    logic master;
    logic cpol;
    logic cpha;
    logic wired_or;
    logic enable;
    logic tx_ie;
  } ctrl_t;

  localparam logic [REG_W-1:0] CTRL_RST = 8'h08;
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  input  logic             ss_n,
  output ctrl_t            ctrl,
  output logic [1:0]       rate,
  output logic             modf
);
  logic [SYNC_STAGES-1:0] ss_sync;
  logic                   fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_sync <= '1;
    else        ss_sync <= {ss_sync[SYNC_STAGES-2:0], ss_n};
  end

  assign fault = ctrl.master & ctrl.enable & ~ss_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= ctrl_t'(CTRL_RST);
      rate <= 2'b00;
      modf <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata);
      if (wr_stat) begin
        rate <= wdata[1:0];
        modf <= 1'b0;
      end
      if (fault) modf <= 1'b1;
      if (fault || modf) ctrl.enable <= 1'b0;
    end
  end

  assert_modf_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> $past(ctrl.master) && $past(ctrl.enable));
  assert_modf_kills_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    modf |-> !ctrl.enable);
  assert_stat_wr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !fault) |=> !modf);
endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold
  import spi_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data,
  input  logic [REG_W-1:0] wdata,
  input  logic             enable,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [REG_W-1:0] tx_data,
  output logic             txe
);
  logic [REG_W-1:0] tx_buf;

  always_ff @(posedge clk) begin
    if (wr_data) tx_buf <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     txe <= 1'b1;
    else if (wr_data)               txe <= 1'b0;
    else if (tx_valid && tx_ready)  txe <= 1'b1;
  end

  assign tx_valid = ~txe & enable;
  assign tx_data  = tx_buf;

  assert_handoff_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !wr_data) |=> txe);
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !txe && tx_data == $past(wdata));
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold
  import spi_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stat,
  input  logic             rd_data,
  input  logic             rx_valid,
  input  logic [REG_W-1:0] rx_data,
  output logic [REG_W-1:0] rx_buf,
  output logic             rxf,
  output logic             ovr
);
  logic seen_rxf, seen_ovr;
  logic clr_rxf, take;

  assign clr_rxf = rd_data & seen_rxf;
  assign take    = rx_valid & (~rxf | clr_rxf);

  always_ff @(posedge clk) begin
    if (take) rx_buf <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf      <= 1'b0;
      ovr      <= 1'b0;
      seen_rxf <= 1'b0;
      seen_ovr <= 1'b0;
    end else begin
      if (take)         rxf <= 1'b1;
      else if (clr_rxf) rxf <= 1'b0;

      if (rx_valid && !take)         ovr <= 1'b1;
      else if (rd_data && seen_ovr)  ovr <= 1'b0;

      if (rd_stat) begin
        seen_rxf <= rxf;
        seen_ovr <= ovr;
      end else if (rd_data) begin
        seen_rxf <= 1'b0;
        seen_ovr <= 1'b0;
      end
    end
  end

  assert_rxf_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf && !rd_data) |=> rxf);
  assert_ovr_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rxf && !clr_rxf) |=> ovr && rx_buf == $past(rx_buf));
  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && clr_rxf) |=> rxf && rx_buf == $past(rx_data));
endmodule

// File: rtl/spi_req_route.sv
module spi_req_route #(
  parameter int N = 2
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  input  logic         dma_sel,
  output logic [N-1:0] cpu_req,
  output logic [N-1:0] dma_req
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic req;
    assign req        = flag[i] & en[i];
    assign cpu_req[i] = req & ~dma_sel;
    assign dma_req[i] = req & dma_sel;
  end
endmodule

// File: rtl/spi_flag_regs.sv
module spi_flag_regs
  import spi_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [REG_W-1:0] tx_data,
  input  logic             rx_valid,
  input  logic [REG_W-1:0] rx_data,
  input  logic             ss_n,
  output logic             cfg_master,
  output logic             cfg_cpol,
  output logic             cfg_cpha,
  output logic             cfg_wired_or,
  output logic             cfg_enable,
  output logic [1:0]       cfg_rate,
  output logic             irq_rx,
  output logic             irq_tx,
  output logic             dma_rx,
  output logic             dma_tx
);
  reg_addr_e        sel;
  ctrl_t            ctrl;
  logic [1:0]       rate;
  logic             modf, txe, rxf, ovr;
  logic [REG_W-1:0] rx_buf;
  logic             wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
  logic [1:0]       cpu_req, dma_req;

  assign sel     = reg_addr_e'(bus_addr);
  assign wr_ctrl = bus_wr & (sel == A_CTRL);
  assign wr_stat = bus_wr & (sel == A_STAT);
  assign wr_data = bus_wr & (sel == A_DATA);
  assign rd_stat = bus_rd & (sel == A_STAT);
  assign rd_data = bus_rd & (sel == A_DATA);

  spi_cfg_regs #(.SYNC_STAGES(SYNC_STAGES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wdata(bus_wdata), .ss_n(ss_n), .ctrl(ctrl), .rate(rate), .modf(modf)
  );

  spi_tx_hold u_tx (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(bus_wdata),
    .enable(ctrl.enable), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .txe(txe)
  );

  spi_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .rd_data(rd_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_buf(rx_buf),
    .rxf(rxf), .ovr(ovr)
  );

  spi_req_route #(.N(2)) u_route (
    .flag({txe, rxf}), .en({ctrl.tx_ie, ctrl.rx_ie}), .dma_sel(ctrl.dma_sel),
    .cpu_req(cpu_req), .dma_req(dma_req)
  );

  assign irq_rx = cpu_req[0];
  assign irq_tx = cpu_req[1];
  assign dma_rx = dma_req[0];
  assign dma_tx = dma_req[1];

  always_comb begin
    case (sel)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = {rxf, 1'b0, ovr, modf, txe, 1'b0, rate};
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = '0;
    endcase
  end

  assign cfg_master   = ctrl.master;
  assign cfg_cpol     = ctrl.cpol;
  assign cfg_cpha     = ctrl.cpha;
  assign cfg_wired_or = ctrl.wired_or;
  assign cfg_enable   = ctrl.enable;
  assign cfg_rate     = rate;

  assert_route_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx || dma_rx) == (rxf && ctrl.rx_ie));
  assert_route_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx || dma_tx) == (txe && ctrl.tx_ie));
  assert_dma_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.dma_sel |-> !dma_rx && !dma_tx);
endmodule

// File: tb/test_spi_flag_regs.sv
module test_spi_flag_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       ss_n = 1'b1;
  logic       cfg_master, cfg_cpol, cfg_cpha, cfg_wired_or, cfg_enable;
  logic [1:0] cfg_rate;
  logic       irq_rx, irq_tx, dma_rx, dma_tx;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_flag_regs i_spi_flag_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .ss_n(ss_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_wired_or(cfg_wired_or), .cfg_enable(cfg_enable), .cfg_rate(cfg_rate),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .dma_rx(dma_rx), .dma_tx(dma_tx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R1 reset state
    bus_read(2'd0, d); chk("R1 ctrl", d, 8'h08);
    bus_read(2'd1, d); chk("R1 status", d, 8'h08);
    chk("R1 requests", {irq_rx, irq_tx, dma_rx, dma_tx, tx_valid}, 5'b0);
    bus_read(2'd3, d); chk("R1 unused addr", d, 8'h00);

    // R2 exhaustive control sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd0, v[7:0]);
      bus_read(2'd0, d); chk("R2 readback", d, v[7:0]);
      chk("R2 cfg pins", {cfg_master, cfg_cpol, cfg_cpha, cfg_wired_or, cfg_enable},
          {v[5], v[4], v[3], v[2], v[1]});
    end

    // R3 status writes touch only rate
    do_reset();
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd1, v[7:0]);
      bus_read(2'd1, d); chk("R3 status", d, {6'b000010, v[1:0]});
      chk("R3 rate pins", cfg_rate, v[1:0]);
    end

    // R4 transmit load and handoff
    do_reset();
    bus_write(2'd0, 8'h02);
    bus_write(2'd2, 8'hA5);
    chk("R4 tx_valid", tx_valid, 1'b1);
    chk("R4 tx_data", tx_data, 8'hA5);
    bus_read(2'd1, d); chk("R4 tx_empty clear", d, 8'h00);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R4 tx_valid after handoff", tx_valid, 1'b0);
    bus_read(2'd1, d); chk("R4 tx_empty set", d, 8'h08);

    // R11 write in the same cycle as handoff
    bus_write(2'd2, 8'hB1);
    @(negedge clk); tx_ready = 1'b1; bus_addr = 2'd2; bus_wdata = 8'hC2; bus_wr = 1'b1;
    #1 chk("R11 old byte offered", tx_data, 8'hB1);
    @(negedge clk); tx_ready = 1'b0; bus_wr = 1'b0; bus_addr = 2'd3;
    chk("R11 new byte kept", tx_data, 8'hC2);
    chk("R11 still valid", tx_valid, 1'b1);
    bus_read(2'd1, d); chk("R11 tx_empty clear", d, 8'h00);

    // R5 R6 receive and clear sequence
    do_reset();
    rx_push(8'h3C);
    bus_read(2'd2, d); chk("R5 data read", d, 8'h3C);
    bus_read(2'd1, d); chk("R6 rx_full kept after lone data read", d, 8'h88);
    bus_read(2'd2, d); chk("R5 data read again", d, 8'h3C);
    bus_read(2'd1, d); chk("R6 rx_full cleared", d, 8'h08);

    // R7 overrun
    rx_push(8'h11);
    rx_push(8'h22);
    bus_read(2'd1, d); chk("R7 overrun set", d, 8'hA8);
    bus_read(2'd2, d); chk("R7 old byte kept", d, 8'h11);
    bus_read(2'd1, d); chk("R7 overrun cleared", d, 8'h08);

    // R8 byte arrives with the clearing read
    rx_push(8'h44);
    bus_read(2'd1, d); chk("R8 armed", d, 8'h88);
    @(negedge clk); bus_addr = 2'd2; bus_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h55;
    #1 chk("R8 read returns old", bus_rdata, 8'h44);
    @(negedge clk); bus_rd = 1'b0; rx_valid = 1'b0; bus_addr = 2'd3;
    bus_read(2'd1, d); chk("R8 full, no overrun", d, 8'h88);
    bus_read(2'd2, d); chk("R8 new byte", d, 8'h55);
    bus_read(2'd1, d); chk("R8 cleared", d, 8'h08);

    // R9 mode fault
    do_reset();
    bus_write(2'd0, 8'h02);          // slave, enabled
    @(negedge clk); ss_n = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(2'd1, d); chk("R9 no fault in slave", d, 8'h08);
    @(negedge clk); ss_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(2'd0, 8'h22);          // master, enabled
    @(negedge clk); ss_n = 1'b0;
    repeat (5) @(negedge clk);
    bus_read(2'd1, d); chk("R9 fault set", d, 8'h18);
    bus_read(2'd0, d); chk("R9 enable forced low", d, 8'h20);
    bus_write(2'd0, 8'h22);
    bus_read(2'd0, d); chk("R9 enable held low", d, 8'h20);
    @(negedge clk); ss_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); chk("R9 fault cleared", d, 8'h08);

    // R10 routing sweep, flags set then clear
    do_reset();
    rx_push(8'h01);
    for (int k = 0; k < 8; k++) begin
      bus_write(2'd0, {k[2], k[1], 5'b0, k[0]});
      chk("R10 routing flags set", {irq_rx, dma_rx, irq_tx, dma_tx},
          {k[2] & ~k[1], k[2] & k[1], k[0] & ~k[1], k[0] & k[1]});
    end
    bus_read(2'd1, d);
    bus_read(2'd2, d);
    bus_write(2'd2, 8'h77);
    for (int k = 0; k < 8; k++) begin
      bus_write(2'd0, {k[2], k[1], 5'b0, k[0]});
      chk("R10 routing flags clear", {irq_rx, dma_rx, irq_tx, dma_tx}, 4'b0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule